// File: doc/BRIEF.md
# SIMD Lane-Wise Equality Compare Unit

This execution unit compares two vector operands lane by lane and returns a mask in which every destination lane is all ones where the two source lanes are equal and all zeros where they differ. One datapath serves integer lanes of 8, 16 or 32 bits and floating-point lanes of single or half precision. Floating-point lanes follow IEEE equality under fixed control settings (NaN never equal, signed zeros equal, denormals flushed to zero), not bitwise identity.

The operation works on one 64-bit register or on a pair of consecutive 64-bit registers. A small decoder turns the type, size and width fields and the three split register indices into lane controls and a legality verdict. The unit receives operand data directly. An illegal combination produces a one-cycle undefined-instruction pulse in place of a result. The result, its valid strobe and the decoded register indices appear one clock after the input strobe.

Top module: `vec_eq_cmp_unit`

## Requirements
- R1: After reset and whenever no legal request was presented on the previous edge, `outValid`, `undefFlag`, `maskOut` and the three index outputs are all zero; a legal request with `inValid` high gives `outValid` high on exactly the next clock cycle only.
- R2: In integer mode (`isFloat`=0), `sizeSel` 00, 01 and 10 select 8-, 16- and 32-bit lanes; each result lane has the lane width and is all ones on exact bit equality and all zeros otherwise.
- R3: In integer mode, `sizeSel`=11 raises the undefined flag.
- R4: In floating-point mode, `sizeSel[0]`=0 selects 32-bit lanes and `sizeSel[0]`=1 selects 16-bit lanes; `sizeSel[1]` has no effect; 16-bit lanes with `halfEn` low raise the undefined flag.
- R5: `wideMode`=0 compares bits 63:0 only and forces `maskOut[127:64]` to zero regardless of the upper operand bits; `wideMode`=1 compares all 128 bits.
- R6: Each 5-bit register index is {hi bit, 4-bit field}; with `wideMode`=1, a 1 in bit 0 of any of the three indices raises the undefined flag, while odd indices are legal with `wideMode`=0.
- R7: A floating-point lane where either operand is a NaN (exponent all ones, fraction nonzero, quiet or signalling) compares not equal, even against an identical bit pattern.
- R8: Positive zero and negative zero compare equal in floating-point mode.
- R9: Floating-point denormals are flushed to zero: a denormal equals zero and any other denormal of either sign.
- R10: When the undefined flag is raised, `outValid` is low and `maskOut` is zero in that cycle, and the flag lasts one cycle per offending request.
- R11: Non-NaN, non-zero floating-point lanes, including infinities, compare equal exactly when their bit patterns match.
- R12: With `outValid`, the outputs `resDst`, `resSrcA` and `resSrcB` carry the 5-bit indices of the request; they are zero otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| inValid | input | 1 | Request strobe |
| isFloat | input | 1 | 1 selects floating-point lanes, 0 integer lanes |
| sizeSel | input | 2 | Lane size field |
| wideMode | input | 1 | 0: 64-bit operation, 1: 128-bit operation |
| halfEn | input | 1 | Half-precision feature enable |
| dstHi | input | 1 | Destination index high bit |
| dstLo | input | 4 | Destination index low field |
| srcAHi | input | 1 | First source index high bit |
| srcALo | input | 4 | First source index low field |
| srcBHi | input | 1 | Second source index high bit |
| srcBLo | input | 4 | Second source index low field |
| opA | input | 128 | First operand |
| opB | input | 128 | Second operand |
| maskOut | output | 128 | Lane mask result |
| outValid | output | 1 | Result valid, one cycle after request |
| undefFlag | output | 1 | Undefined-instruction pulse |
| resDst | output | 5 | Destination index of the result |
| resSrcA | output | 5 | First source index of the result |
| resSrcB | output | 5 | Second source index of the result |

## Verification
Integer vectors are built so that the same pair of operands gives different masks at 8, 16 and 32 bits, which shows that a lane only hits when all its bytes match. Floating-point vectors set NaN against an identical NaN, signed zeros, denormals against zero, opposite-sign ones and infinities side by side, which separates IEEE equality from a bitwise compare. Narrow requests with differing upper halves, wide requests with a miss only in the top half, odd indices in both widths and each illegal size combination check the width handling and the undefined path. Back-to-back requests and a mid-request reset check the one-cycle timing.

// File: rtl/vcmp_pkg.sv
package vcmp_pkg;

  localparam int CHUNK_W = 64;
  localparam int BYTES_PER_CHUNK = CHUNK_W / 8;

  typedef enum logic [2:0] {
    LK_I8  = 3'd0,
    LK_I16 = 3'd1,
    LK_I32 = 3'd2,
    LK_F16 = 3'd3,
    LK_F32 = 3'd4
  } laneKind_e;

  // Strobes from the control block to the datapath
  typedef struct packed {
    logic      fire;
    laneKind_e kind;
    logic      wide;
  } ctrlStrobe_t;

  // IEEE equality for single precision, denormals flushed to zero
  function automatic logic fp32Eq(input logic [31:0] a, input logic [31:0] b);
    logic nanA, nanB, zeroA, zeroB;
    nanA  = (&a[30:23]) && (|a[22:0]);
    nanB  = (&b[30:23]) && (|b[22:0]);
    zeroA = (a[30:23] == 8'd0);
    zeroB = (b[30:23] == 8'd0);
    return !nanA && !nanB && ((zeroA && zeroB) || (a == b));
  endfunction

  // IEEE equality for half precision, denormals flushed to zero
  function automatic logic fp16Eq(input logic [15:0] a, input logic [15:0] b);
    logic nanA, nanB, zeroA, zeroB;
    nanA  = (&a[14:10]) && (|a[9:0]);
    nanB  = (&b[14:10]) && (|b[9:0]);
    zeroA = (a[14:10] == 5'd0);
    zeroB = (b[14:10] == 5'd0);
    return !nanA && !nanB && ((zeroA && zeroB) || (a == b));
  endfunction

endpackage

// File: rtl/vcmp_ctrl.sv
module vcmp_ctrl
  import vcmp_pkg::*;
#(
  parameter int IDX_FIELD_W = 4,
  localparam int IDX_W = IDX_FIELD_W + 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   inValid,
  input  logic                   isFloat,
  input  logic [1:0]             sizeSel,
  input  logic                   wideMode,
  input  logic                   halfEn,
  input  logic                   dstHi,
  input  logic [IDX_FIELD_W-1:0] dstLo,
  input  logic                   srcAHi,
  input  logic [IDX_FIELD_W-1:0] srcALo,
  input  logic                   srcBHi,
  input  logic [IDX_FIELD_W-1:0] srcBLo,
  output ctrlStrobe_t            strobe,
  output logic                   undefFlag,
  output logic [IDX_W-1:0]       resDst,
  output logic [IDX_W-1:0]       resSrcA,
  output logic [IDX_W-1:0]       resSrcB
);

  logic [IDX_W-1:0] dstIdx, srcAIdx, srcBIdx;
  logic             badIntSize, badHalf, badAlign, illegal;
  laneKind_e        kindDec;

  assign dstIdx  = {dstHi, dstLo};
  assign srcAIdx = {srcAHi, srcALo};
  assign srcBIdx = {srcBHi, srcBLo};

  always_comb begin
    if (isFloat) begin
      kindDec = sizeSel[0] ? LK_F16 : LK_F32;
    end else begin
      case (sizeSel)
        2'b00:   kindDec = LK_I8;
        2'b01:   kindDec = LK_I16;
        2'b10:   kindDec = LK_I32;
        default: kindDec = LK_I8;
      endcase
    end
  end

  assign badIntSize = !isFloat && (sizeSel == 2'b11);
  assign badHalf    = isFloat && sizeSel[0] && !halfEn;
  assign badAlign   = wideMode && (dstIdx[0] || srcAIdx[0] || srcBIdx[0]);
  assign illegal    = badIntSize || badHalf || badAlign;

  assign strobe.fire = inValid && !illegal;
  assign strobe.kind = kindDec;
  assign strobe.wide = wideMode;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      undefFlag <= 1'b0;
      resDst    <= '0;
      resSrcA   <= '0;
      resSrcB   <= '0;
    end else begin
      undefFlag <= inValid && illegal;
      if (strobe.fire) begin
        resDst  <= dstIdx;
        resSrcA <= srcAIdx;
        resSrcB <= srcBIdx;
      end else begin
        resDst  <= '0;
        resSrcA <= '0;
        resSrcB <= '0;
      end
    end
  end

  // R3: reserved integer size is flagged
  a_r3_int_size_undef: assert property (@(posedge clk) disable iff (!rst_n)
    inValid && !isFloat && (sizeSel == 2'b11) |=> undefFlag);

  // R4: half precision without the feature is flagged
  a_r4_half_gate: assert property (@(posedge clk) disable iff (!rst_n)
    inValid && isFloat && sizeSel[0] && !halfEn |=> undefFlag);

  // R6: odd index in wide mode is flagged
  a_r6_wide_align: assert property (@(posedge clk) disable iff (!rst_n)
    inValid && wideMode && (dstLo[0] || srcALo[0] || srcBLo[0]) |=> undefFlag);

  // R12: indices are zero whenever no result was produced
  a_r12_idx_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !inValid |=> (resDst == '0) && (resSrcA == '0) && (resSrcB == '0));

endmodule

// File: rtl/vcmp_datapath.sv
module vcmp_datapath
  import vcmp_pkg::*;
#(
  parameter int DATA_W = 128,
  localparam int NUM_CHUNKS = DATA_W / CHUNK_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  ctrlStrobe_t       strobe,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  output logic [DATA_W-1:0] maskOut,
  output logic              outValid
);

  logic [DATA_W-1:0] maskNext;

  for (genvar c = 0; c < NUM_CHUNKS; c++) begin : g_chunk
    logic [CHUNK_W-1:0]         aC, bC;
    logic [BYTES_PER_CHUNK-1:0] byteEq;
    logic [BYTES_PER_CHUNK-1:0] byteHit;
    logic [BYTES_PER_CHUNK/2-1:0] halfFpEq;
    logic [BYTES_PER_CHUNK/4-1:0] wordFpEq;
    logic                       chunkOn;

    assign aC      = opA[c*CHUNK_W +: CHUNK_W];
    assign bC      = opB[c*CHUNK_W +: CHUNK_W];
    assign chunkOn = (c == 0) || strobe.wide;

    for (genvar j = 0; j < BYTES_PER_CHUNK; j++) begin : g_byteEq
      assign byteEq[j] = (aC[j*8 +: 8] == bC[j*8 +: 8]);
    end

    for (genvar h = 0; h < BYTES_PER_CHUNK/2; h++) begin : g_half
      assign halfFpEq[h] = fp16Eq(aC[h*16 +: 16], bC[h*16 +: 16]);
    end

    for (genvar w = 0; w < BYTES_PER_CHUNK/4; w++) begin : g_word
      assign wordFpEq[w] = fp32Eq(aC[w*32 +: 32], bC[w*32 +: 32]);
    end

    for (genvar j = 0; j < BYTES_PER_CHUNK; j++) begin : g_byteHit
      localparam int H0 = (j / 2) * 2;
      localparam int W0 = (j / 4) * 4;
      always_comb begin
        case (strobe.kind)
          LK_I8:   byteHit[j] = byteEq[j];
          LK_I16:  byteHit[j] = byteEq[H0] && byteEq[H0+1];
          LK_I32:  byteHit[j] = &byteEq[W0 +: 4];
          LK_F16:  byteHit[j] = halfFpEq[j/2];
          LK_F32:  byteHit[j] = wordFpEq[j/4];
          default: byteHit[j] = 1'b0;
        endcase
      end
      assign maskNext[c*CHUNK_W + j*8 +: 8] = {8{byteHit[j] && chunkOn}};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      maskOut  <= '0;
      outValid <= 1'b0;
    end else begin
      outValid <= strobe.fire;
      maskOut  <= strobe.fire ? maskNext : '0;
    end
  end

  // R5: narrow results leave the upper half clear
  a_r5_upper_clear: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.fire && !strobe.wide |=> (maskOut[DATA_W-1:CHUNK_W] == '0));

  // R2: a 16-bit integer lane is uniform
  a_r2_i16_uniform: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.fire && (strobe.kind == LK_I16) |=>
      (maskOut[15:0] == 16'h0000) || (maskOut[15:0] == 16'hFFFF));

  // R2: a 32-bit lane is uniform
  a_r2_w32_uniform: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.fire && ((strobe.kind == LK_I32) || (strobe.kind == LK_F32)) |=>
      (maskOut[31:0] == 32'h0) || (maskOut[31:0] == 32'hFFFF_FFFF));

endmodule

// File: rtl/vec_eq_cmp_unit.sv
module vec_eq_cmp_unit
  import vcmp_pkg::*;
#(
  parameter int DATA_W = 128,
  parameter int IDX_FIELD_W = 4,
  localparam int IDX_W = IDX_FIELD_W + 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   inValid,
  input  logic                   isFloat,
  input  logic [1:0]             sizeSel,
  input  logic                   wideMode,
  input  logic                   halfEn,
  input  logic                   dstHi,
  input  logic [IDX_FIELD_W-1:0] dstLo,
  input  logic                   srcAHi,
  input  logic [IDX_FIELD_W-1:0] srcALo,
  input  logic                   srcBHi,
  input  logic [IDX_FIELD_W-1:0] srcBLo,
  input  logic [DATA_W-1:0]      opA,
  input  logic [DATA_W-1:0]      opB,
  output logic [DATA_W-1:0]      maskOut,
  output logic                   outValid,
  output logic                   undefFlag,
  output logic [IDX_W-1:0]       resDst,
  output logic [IDX_W-1:0]       resSrcA,
  output logic [IDX_W-1:0]       resSrcB
);

  ctrlStrobe_t strobe;

  vcmp_ctrl #(.IDX_FIELD_W(IDX_FIELD_W)) i_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .inValid  (inValid),
    .isFloat  (isFloat),
    .sizeSel  (sizeSel),
    .wideMode (wideMode),
    .halfEn   (halfEn),
    .dstHi    (dstHi),
    .dstLo    (dstLo),
    .srcAHi   (srcAHi),
    .srcALo   (srcALo),
    .srcBHi   (srcBHi),
    .srcBLo   (srcBLo),
    .strobe   (strobe),
    .undefFlag(undefFlag),
    .resDst   (resDst),
    .resSrcA  (resSrcA),
    .resSrcB  (resSrcB)
  );

  vcmp_datapath #(.DATA_W(DATA_W)) i_datapath (
    .clk     (clk),
    .rst_n   (rst_n),
    .strobe  (strobe),
    .opA     (opA),
    .opB     (opB),
    .maskOut (maskOut),
    .outValid(outValid)
  );

  // R10: an undefined pulse carries no result
  a_r10_undef_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    undefFlag |-> !outValid && (maskOut == '0));

  // R1: no request, no output the next cycle
  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !inValid |=> !outValid && !undefFlag);

  // R10: one flag per offending request
  a_r10_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    undefFlag && !$past(inValid) |-> 1'b0);

endmodule

// File: tb/test_vec_eq_cmp_unit.sv
module test_vec_eq_cmp_unit;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         inValid = 1'b0;
  logic         isFloat = 1'b0;
  logic [1:0]   sizeSel = 2'b00;
  logic         wideMode = 1'b0;
  logic         halfEn = 1'b0;
  logic [4:0]   dIdx = '0, aIdx = '0, bIdx = '0;
  logic [127:0] opA = '0, opB = '0;
  logic [127:0] maskOut;
  logic         outValid, undefFlag;
  logic [4:0]   resDst, resSrcA, resSrcB;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  vec_eq_cmp_unit i_vec_eq_cmp_unit (
    .clk(clk), .rst_n(rst_n), .inValid(inValid), .isFloat(isFloat),
    .sizeSel(sizeSel), .wideMode(wideMode), .halfEn(halfEn),
    .dstHi(dIdx[4]), .dstLo(dIdx[3:0]),
    .srcAHi(aIdx[4]), .srcALo(aIdx[3:0]),
    .srcBHi(bIdx[4]), .srcBLo(bIdx[3:0]),
    .opA(opA), .opB(opB), .maskOut(maskOut), .outValid(outValid),
    .undefFlag(undefFlag), .resDst(resDst), .resSrcA(resSrcA), .resSrcB(resSrcB)
  );

  typedef struct packed {
    logic         fp;
    logic [1:0]   sz;
    logic         wide;
    logic         half;
    logic [4:0]   d, a, b;
    logic [127:0] va, vb, expMask;
    logic         expUndef;
  } vec_t;

  localparam int NV = 18;
  localparam vec_t VECS [NV] = '{
    // 0 R2 I8
    '{1'b0, 2'b00, 1'b0, 1'b0, 5'h13, 5'h05, 5'h1F,
      {64'h0, 64'h1122334455667788}, {64'h0, 64'h11AA3344556677FF},
      {64'h0, 64'hFF00FFFFFFFFFF00}, 1'b0},
    // 1 R2 I16
    '{1'b0, 2'b01, 1'b0, 1'b0, 5'h01, 5'h02, 5'h03,
      {64'h0, 64'h1122334455667788}, {64'h0, 64'h11AA3344556677FF},
      {64'h0, 64'h0000FFFFFFFF0000}, 1'b0},
    // 2 R2 I32
    '{1'b0, 2'b10, 1'b0, 1'b0, 5'h04, 5'h06, 5'h08,
      {64'h0, 64'h1122334455667788}, {64'h0, 64'h11AA3344556677FF},
      {64'h0, 64'h0000000000000000}, 1'b0},
    // 3 R2 I32 partial
    '{1'b0, 2'b10, 1'b0, 1'b0, 5'h0A, 5'h0B, 5'h0C,
      {64'h0, 64'hDEADBEEF12345678}, {64'h0, 64'hDEADBEEF12345679},
      {64'h0, 64'hFFFFFFFF00000000}, 1'b0},
    // 4 R5 wide I8, miss in top half
    '{1'b0, 2'b00, 1'b1, 1'b0, 5'h02, 5'h04, 5'h10,
      {64'hAAAAAAAAAAAAAAAA, 64'h0}, {64'hAAAAAAAAAAAAAA00, 64'h0},
      {64'hFFFFFFFFFFFFFF00, 64'hFFFFFFFFFFFFFFFF}, 1'b0},
    // 5 R5 narrow ignores differing upper half
    '{1'b0, 2'b00, 1'b0, 1'b0, 5'h15, 5'h17, 5'h19,
      {64'h123456789ABCDEF0, 64'h0}, {64'h0, 64'h0},
      {64'h0, 64'hFFFFFFFFFFFFFFFF}, 1'b0},
    // 6 R8 R11 F32 one and signed zeros
    '{1'b1, 2'b00, 1'b0, 1'b0, 5'h00, 5'h01, 5'h02,
      {64'h0, 64'h3F80000000000000}, {64'h0, 64'h3F80000080000000},
      {64'h0, 64'hFFFFFFFFFFFFFFFF}, 1'b0},
    // 7 R7 F32 quiet NaN vs itself, inf vs inf
    '{1'b1, 2'b00, 1'b0, 1'b0, 5'h03, 5'h05, 5'h07,
      {64'h0, 64'h7FC000007F800000}, {64'h0, 64'h7FC000007F800000},
      {64'h0, 64'h00000000FFFFFFFF}, 1'b0},
    // 8 R9 F32 denormals of opposite sign, one vs minus one
    '{1'b1, 2'b00, 1'b0, 1'b0, 5'h09, 5'h0B, 5'h0D,
      {64'h0, 64'h000000013F800000}, {64'h0, 64'h80400000BF800000},
      {64'h0, 64'hFFFFFFFF00000000}, 1'b0},
    // 9 R9 F16: one, NaN, denormal vs zero, -0 vs +0
    '{1'b1, 2'b01, 1'b0, 1'b1, 5'h11, 5'h12, 5'h13,
      {64'h0, 64'h3C007E0000018000}, {64'h0, 64'h3C007E0000000000},
      {64'h0, 64'hFFFF0000FFFFFFFF}, 1'b0},
    // 10 R7 F16: signalling NaN, +inf, -inf vs +inf, one vs next
    '{1'b1, 2'b01, 1'b0, 1'b1, 5'h14, 5'h16, 5'h18,
      {64'h0, 64'h7C017C00FC003C00}, {64'h0, 64'h7C017C007C003C01},
      {64'h0, 64'h0000FFFF00000000}, 1'b0},
    // 11 R5 wide F32 with signalling NaN and denormal vs zero
    '{1'b1, 2'b00, 1'b1, 1'b0, 5'h1E, 5'h1C, 5'h0E,
      {64'h400000007F800001, 64'h0000000012345678},
      {64'h400000007F800001, 64'h007FFFFF12345678},
      {64'hFFFFFFFF00000000, 64'hFFFFFFFFFFFFFFFF}, 1'b0},
    // 12 R3 reserved integer size
    '{1'b0, 2'b11, 1'b0, 1'b0, 5'h01, 5'h01, 5'h01,
      {64'h0, 64'h0}, {64'h0, 64'h0}, 128'h0, 1'b1},
    // 13 R4 half without feature
    '{1'b1, 2'b01, 1'b0, 1'b0, 5'h02, 5'h02, 5'h02,
      {64'h0, 64'h0}, {64'h0, 64'h0}, 128'h0, 1'b1},
    // 14 R6 wide with odd second source
    '{1'b0, 2'b00, 1'b1, 1'b0, 5'h02, 5'h04, 5'h11,
      {64'h0, 64'h0}, {64'h0, 64'h0}, 128'h0, 1'b1},
    // 15 R4 fp with size bit 1 set still single precision
    '{1'b1, 2'b10, 1'b0, 1'b0, 5'h06, 5'h07, 5'h08,
      {64'h0, 64'h3F8000003F800000}, {64'h0, 64'h3F8000003F800000},
      {64'h0, 64'hFFFFFFFFFFFFFFFF}, 1'b0},
    // 16 R6 wide with odd destination
    '{1'b0, 2'b10, 1'b1, 1'b0, 5'h03, 5'h04, 5'h06,
      {64'h0, 64'h0}, {64'h0, 64'h0}, 128'h0, 1'b1},
    // 17 R2 wide I16 all equal
    '{1'b0, 2'b01, 1'b1, 1'b0, 5'h1A, 5'h0C, 5'h08,
      128'h0, 128'h0, {64'hFFFFFFFFFFFFFFFF, 64'hFFFFFFFFFFFFFFFF}, 1'b0}
  };

  string vecTag [NV] = '{"R2", "R2", "R2", "R2", "R5", "R5", "R8", "R7", "R9",
                         "R9", "R7", "R5", "R3", "R4", "R6", "R4", "R6", "R2"};

  task automatic check(input string tag, input string what,
                       input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic driveVec(input vec_t v);
    inValid  = 1'b1;
    isFloat  = v.fp;
    sizeSel  = v.sz;
    wideMode = v.wide;
    halfEn   = v.half;
    dIdx     = v.d;
    aIdx     = v.a;
    bIdx     = v.b;
    opA      = v.va;
    opB      = v.vb;
  endtask

  task automatic checkVec(input int i);
    vec_t v;
    v = VECS[i];
    check(vecTag[i], $sformatf("vec%0d mask", i), maskOut, v.expMask);
    check("R1", $sformatf("vec%0d valid", i), {127'h0, outValid}, {127'h0, !v.expUndef});
    check("R10", $sformatf("vec%0d undef", i), {127'h0, undefFlag}, {127'h0, v.expUndef});
    check("R12", $sformatf("vec%0d dst", i), {123'h0, resDst}, {123'h0, v.expUndef ? 5'h0 : v.d});
    check("R12", $sformatf("vec%0d srcA", i), {123'h0, resSrcA}, {123'h0, v.expUndef ? 5'h0 : v.a});
    check("R12", $sformatf("vec%0d srcB", i), {123'h0, resSrcB}, {123'h0, v.expUndef ? 5'h0 : v.b});
  endtask

  task automatic checkIdle(input string tag);
    check(tag, "idle valid", {127'h0, outValid}, 128'h0);
    check(tag, "idle undef", {127'h0, undefFlag}, 128'h0);
    check(tag, "idle mask", maskOut, 128'h0);
    check(tag, "idle dst", {123'h0, resDst}, 128'h0);
  endtask

  initial begin
    repeat (10000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    checkIdle("R1");
    rst_n = 1'b1;
    @(negedge clk);
    checkIdle("R1");

    // Table walk, back to back
    for (int i = 0; i < NV; i++) begin
      if (i > 0) checkVec(i - 1);
      driveVec(VECS[i]);
      @(negedge clk);
    end
    checkVec(NV - 1);
    inValid = 1'b0;
    @(negedge clk);
    // R1 and R10: outputs drop one cycle after the last request
    checkIdle("R1");

    // R5: same operands, narrow then wide, top half differs only
    driveVec(VECS[4]);
    wideMode = 1'b0;
    @(negedge clk);
    check("R5", "narrow upper", maskOut, {64'h0, 64'hFFFFFFFFFFFFFFFF});
    inValid = 1'b0;
    @(negedge clk);

    // R10: undefined request followed by idle gives a single pulse
    driveVec(VECS[13]);
    @(negedge clk);
    check("R10", "undef pulse", {127'h0, undefFlag}, 128'h1);
    inValid = 1'b0;
    @(negedge clk);
    check("R10", "undef clears", {127'h0, undefFlag}, 128'h0);

    // R6: odd indices are legal in narrow mode
    driveVec(VECS[14]);
    wideMode = 1'b0;
    @(negedge clk);
    check("R6", "odd narrow valid", {127'h0, outValid}, 128'h1);
    check("R6", "odd narrow undef", {127'h0, undefFlag}, 128'h0);
    inValid = 1'b0;

    // R1: reset during a request wipes the output
    @(negedge clk);
    driveVec(VECS[0]);
    rst_n = 1'b0;
    @(negedge clk);
    checkIdle("R1");
    inValid = 1'b0;
    rst_n = 1'b1;
    @(negedge clk);
    checkIdle("R1");

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule